// File: doc/BRIEF.md
# Remote Alarm Integrator for a Channelised T1 Stream

The block watches the second bit of every 8-bit voice channel in a received T1 stream. When the far end reports a remote alarm it forces that bit to zero in every channel. The block counts the ones that still arrive in that position over fixed integration windows. A window made of `PERIOD_MS` millisecond ticks (48 by default) that contains no more than `ONES_TOL` ones (16 by default) counts as a qualifying window. At the end of each window the block publishes a short-term sample flag.

A second, slower level turns that flag into a persistent alarm. The alarm sets after `SET_PERIODS` consecutive qualifying windows (13 windows, about 600 ms). Once set, it does not drop as soon as the condition ends. It clears only after `CLEAR_MS` ticks (200 ms) have passed since the first window that failed. Upstream framing logic marks which bits to sample, marks frame starts, and provides a 1 ms tick.

Top module: `yel_integ`

## Requirements
- R1: After reset, `smp_flag` and `alarm` are both 0, and the window, ones, run and clear counters all start from zero.
- R2: `smp_flag` changes only on the tick that completes `PERIOD_MS` ticks since reset or since the previous window end. The new value is visible in the cycle after that tick.
- R3: At a window end, `smp_flag` becomes 1 if the window held at most `ONES_TOL` (16) ones, and 0 if it held 17 or more. A sample presented in the same cycle as the closing tick belongs to the closing window.
- R4: A sample counts only when `rx_vld`=1 and `b2_slot`=1. A one presented with either of these at 0 has no effect.
- R5: A window in which `frm_mark` never pulsed does not qualify, whatever its ones count.
- R6: `alarm` sets at the end of the `SET_PERIODS`-th (13th) consecutive qualifying window. Any failing window restarts that count from zero.
- R7: While `alarm` is set, the first failing window starts a clear delay. `alarm` drops on the `CLEAR_MS`-th (200th) tick after that window's closing tick.
- R8: A qualifying window that ends during the clear delay cancels it, and `alarm` stays set. A later failing window starts a new delay from zero.
- R9: Failing windows that end while a clear delay is already running do not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Received data bit |
| rx_vld | input | 1 | `rx_bit` carries a bit this cycle |
| b2_slot | input | 1 | Current bit is bit 2 of a channel |
| frm_mark | input | 1 | Frame-start pulse |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| smp_flag | output | 1 | Result of the last integration window |
| alarm | output | 1 | Persistent remote alarm |

## Verification
The hardest situations to reach are those that occur while the clear delay is running. The first is a qualifying window that lands inside the delay and must cancel it. The second is a failing window that lands inside the delay and must leave it running. Both require the alarm to be set first, which means thirteen qualifying windows. The bench therefore builds the alarm, then drives chosen patterns of failing and qualifying windows. It compares `alarm` with an arithmetic model at every tick, so an early or late clear shows up to the exact millisecond. A sweep of 0 to 20 ones per window, mixed with ones that have no valid strobe or fall outside the bit-2 slot, covers the tolerance edge.

// File: rtl/yel_integ.sv
module yel_integ #(
  parameter int PERIOD_MS   = 48,
  parameter int ONES_TOL    = 16,
  parameter int SET_PERIODS = 13,
  parameter int CLEAR_MS    = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_bit,
  input  logic rx_vld,
  input  logic b2_slot,
  input  logic frm_mark,
  input  logic tick_ms,
  output logic smp_flag,
  output logic alarm
);
  localparam int MW = $clog2(PERIOD_MS);
  localparam int OW = $clog2(ONES_TOL + 2);
  localparam int RW = $clog2(SET_PERIODS + 1);
  localparam int CW = $clog2(CLEAR_MS);
  localparam logic [MW-1:0] MS_LAST  = MW'(PERIOD_MS - 1);
  localparam logic [OW-1:0] ONES_MAX = OW'(ONES_TOL);
  localparam logic [OW-1:0] ONES_SAT = OW'(ONES_TOL + 1);
  localparam logic [RW-1:0] RUN_FULL = RW'(SET_PERIODS);
  localparam logic [CW-1:0] CLR_LAST = CW'(CLEAR_MS - 1);

  logic [MW-1:0] ms_cnt;
  logic [OW-1:0] ones_cnt;
  logic [RW-1:0] run_cnt;
  logic [CW-1:0] clr_cnt;
  logic          frm_seen, clr_act;

  wire           hit     = rx_vld & b2_slot & rx_bit;
  wire           per_end = tick_ms && (ms_cnt == MS_LAST);
  wire [OW-1:0]  ones_nx = (hit && ones_cnt != ONES_SAT) ? ones_cnt + 1'b1 : ones_cnt;
  wire           qual    = (frm_seen | frm_mark) && (ones_nx <= ONES_MAX);
  wire [RW-1:0]  run_nx  = (run_cnt == RUN_FULL) ? run_cnt : run_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ms_cnt   <= '0;
      ones_cnt <= '0;
      frm_seen <= 1'b0;
      smp_flag <= 1'b0;
      run_cnt  <= '0;
    end else begin
      if (tick_ms) ms_cnt <= per_end ? '0 : ms_cnt + 1'b1;
      ones_cnt <= per_end ? '0 : ones_nx;
      frm_seen <= per_end ? 1'b0 : (frm_seen | frm_mark);
      if (per_end) begin
        smp_flag <= qual;
        run_cnt  <= qual ? run_nx : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm   <= 1'b0;
      clr_act <= 1'b0;
      clr_cnt <= '0;
    end else if (per_end && qual) begin
      clr_act <= 1'b0;
      if (run_nx == RUN_FULL) alarm <= 1'b1;
    end else if (per_end && alarm && !clr_act) begin
      clr_act <= 1'b1;
      clr_cnt <= '0;
    end else if (clr_act && tick_ms) begin
      if (clr_cnt == CLR_LAST) begin
        alarm   <= 1'b0;
        clr_act <= 1'b0;
      end else begin
        clr_cnt <= clr_cnt + 1'b1;
      end
    end
  end

  a_r2_flag_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !per_end |=> $stable(smp_flag));
  a_r3_ones_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ones_cnt <= ONES_SAT);
  a_r6_rise_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> smp_flag && $past(per_end));
  a_r6_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= RUN_FULL);
  a_r7_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm) |-> $past(tick_ms) && $past(clr_act));
  a_r8_delay_needs_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |-> alarm);
endmodule

// File: tb/sim_yel_integ.sv
module sim_yel_integ;
  logic clk = 0, rst_n = 0;
  logic rx_bit = 0, rx_vld = 0, b2_slot = 0, frm_mark = 0, tick_ms = 0;
  logic smp_flag, alarm;
  int total = 0, bad = 0;
  bit done = 0;

  int m_run = 0, m_cms = 0;
  bit m_alarm = 0, m_clr = 0, m_flag = 0;

  always #2.5 clk = ~clk;

  yel_integ u0 (.clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_vld(rx_vld),
                .b2_slot(b2_slot), .frm_mark(frm_mark), .tick_ms(tick_ms),
                .smp_flag(smp_flag), .alarm(alarm));

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic b, input logic v, input logic s, input logic f, input logic t);
    rx_bit = b; rx_vld = v; b2_slot = s; frm_mark = f; tick_ms = t;
    @(negedge clk);
    rx_bit = 0; rx_vld = 0; b2_slot = 0; frm_mark = 0; tick_ms = 0;
  endtask

  task automatic period(input int n_ones, input bit frame, input string tag);
    bit q;
    for (int m = 0; m < 48; m++) begin
      if (m == 0 && frame) cyc(0, 0, 0, 1, 0);
      cyc(2 * m < n_ones, 1, 1, 0, 0);
      cyc(1, 1, 0, 0, 0);
      cyc(1, 0, 1, 0, 0);
      if (m == 47) begin
        rx_bit = (2 * m + 1 < n_ones); rx_vld = 1; b2_slot = 1; tick_ms = 1;
        @(negedge clk);
        rx_bit = 0; rx_vld = 0; b2_slot = 0; tick_ms = 0;
      end else begin
        cyc(2 * m + 1 < n_ones, 1, 1, 0, 0);
        cyc(0, 0, 0, 0, 1);
      end
      if (m == 47) begin
        q = frame && (n_ones <= 16);
        m_flag = q;
        if (q) begin
          m_clr = 0;
          if (m_run < 13) m_run++;
          if (m_run == 13) m_alarm = 1;
        end else begin
          m_run = 0;
          if (m_alarm && !m_clr) begin m_clr = 1; m_cms = 0; end
          else if (m_clr) begin
            m_cms++;
            if (m_cms == 200) begin m_alarm = 0; m_clr = 0; end
          end
        end
        chk($sformatf("%s smp_flag n=%0d frame=%0b", tag, n_ones, frame), smp_flag, m_flag);
      end else begin
        if (m_clr) begin
          m_cms++;
          if (m_cms == 200) begin m_alarm = 0; m_clr = 0; end
        end
        if (m == 0) chk({tag, " R2 flag held mid-window"}, smp_flag, m_flag);
      end
      chk({tag, " alarm"}, alarm, m_alarm);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 smp_flag reset", smp_flag, 1'b0);
    chk("R1 alarm reset", alarm, 1'b0);
    rst_n = 1;
    @(negedge clk);
    // R3 R4 tolerance sweep with decoy ones outside the slot or strobe
    for (int n = 0; n <= 20; n++) period(n, 1, "R3/R4");
    period(40, 1, "R3");
    // R5 no frame start in window
    period(0, 0, "R5");
    period(0, 1, "R5");
    period(0, 0, "R5");
    // R6 twelve then fail then thirteen
    for (int k = 0; k < 12; k++) period(3, 1, "R6");
    period(17, 1, "R6");
    for (int k = 0; k < 13; k++) period(16, 1, "R6");
    // R7 R9 run of failing windows
    for (int k = 0; k < 6; k++) period(30, 1, "R7/R9");
    // R8 cancel and restart
    for (int k = 0; k < 13; k++) period(0, 1, "R8");
    period(0, 0, "R8");
    period(5, 1, "R8");
    period(1, 1, "R8");
    period(25, 1, "R8");
    period(10, 1, "R8");
    period(25, 1, "R8");
    for (int k = 0; k < 5; k++) period(0, 0, "R7/R9");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule